// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits on the write side of a byte-wide NOR-style flash bus. It has a 19-bit address, 8-bit data and an active-low write strobe. It watches every write cycle and looks for the six-write unlock sequence that asks for a whole-array erase or for the erase of one sector. A valid sequence produces a one-cycle start strobe to the erase engine. With that strobe come a flag that tells whole-array erase from sector erase, and the latched address that picks the sector.

The write strobe is sampled on a fast system clock. The address is taken when the strobe falls and the data byte when it rises. Any write that breaks the sequence returns the decoder to read mode. From the start strobe until the engine reports completion, the decoder ignores every write. On completion it drops the erase flags and clears the latched address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, erase_start, erase_active and erase_chip are 0 and erase_addr is 0.
- R2: Six writes form a whole-array erase: (addr[10:0]=0x555, data 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), then data 0x10 at any address. In the clock cycle after the sixth write's rising strobe edge is sampled, erase_start pulses with erase_chip=1 and erase_addr=0.
- R3: The same first five writes followed by data 0x30 start a sector erase: erase_start pulses with erase_chip=0 and erase_addr equal to the sixth write's full address. Bits [18:16] of that address select the sector. erase_addr holds this value while erase_active is high.
- R4: A write's address is captured when the strobe is sampled low after being high. A change of address while the strobe stays low has no effect. The data byte is taken when the strobe is sampled high after being low.
- R5: A write that does not match the next expected cycle, including a sixth write whose data is neither 0x10 nor 0x30, starts no erase and returns the decoder to the first cycle. A complete sequence written after it is accepted.
- R6: In the five unlock and set-up writes only address bits [10:0] are compared, so bits [18:11] may take any value.
- R7: erase_active rises together with erase_start and stays high until erase_done. While it is high, writes are ignored, so a complete sequence produces no new start.
- R8: erase_done while erase_active is high clears erase_active, erase_chip and erase_addr on the next clock edge.
- R9: erase_start is never high for two cycles in a row.
- R10: erase_done while no erase is active has no effect on the outputs or on a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the write strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Active-low write strobe of the flash bus |
| addr | input | 19 | Bus address |
| wdata | input | 8 | Bus write data |
| erase_done | input | 1 | Erase engine reports completion |
| erase_start | output | 1 | One-cycle erase start strobe |
| erase_chip | output | 1 | 1 = whole-array erase, 0 = sector erase |
| erase_addr | output | 19 | Latched address of the sector to erase |
| erase_active | output | 1 | An erase is running; writes are ignored |

## Verification
The hardest case to reach is a sequence that breaks at the very last step. After five valid writes, the sixth carries a byte that is neither erase command. The decoder must then start nothing, and the next full sequence must still be accepted. The bench drives this case, and a break in the second write, through the same write task it uses for valid sequences. A second hard case is a write whose address moves while the strobe is held low. The bench uses a task that changes the address between the two edges, and the result shows on erase_addr.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int UW = 11,
  parameter logic [UW-1:0] ADDR_A = 11'h555,
  parameter logic [UW-1:0] ADDR_B = 11'h2AA,
  parameter logic [DW-1:0] KEY_A = 8'hAA,
  parameter logic [DW-1:0] KEY_B = 8'h55,
  parameter logic [DW-1:0] SETUP = 8'h80,
  parameter logic [DW-1:0] CHIP_CMD = 8'h10,
  parameter logic [DW-1:0] SECT_CMD = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          erase_done,
  output logic          erase_start,
  output logic          erase_chip,
  output logic [AW-1:0] erase_addr,
  output logic          erase_active
);
  localparam logic [2:0] LAST = 3'd5;
  localparam logic [2:0] BUSY = 3'd6;

  logic          we_q;
  logic [2:0]    step;
  logic [AW-1:0] addr_lat;
  logic [UW-1:0] exp_a;
  logic [DW-1:0] exp_d;

  wire fall    = we_q & ~we_n;
  wire rise    = ~we_q & we_n;
  wire hit     = (addr_lat[UW-1:0] == exp_a) && (wdata == exp_d);
  wire is_chip = (wdata == CHIP_CMD);
  wire is_sect = (wdata == SECT_CMD);

  assign erase_active = (step == BUSY);

  always_comb begin
    case (step)
      3'd0, 3'd3: begin exp_a = ADDR_A; exp_d = KEY_A; end
      3'd1, 3'd4: begin exp_a = ADDR_B; exp_d = KEY_B; end
      3'd2:       begin exp_a = ADDR_A; exp_d = SETUP; end
      default:    begin exp_a = '0;     exp_d = '0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q        <= 1'b1;
      step        <= '0;
      addr_lat    <= '0;
      erase_start <= 1'b0;
      erase_chip  <= 1'b0;
      erase_addr  <= '0;
    end else begin
      we_q        <= we_n;
      erase_start <= 1'b0;
      if (step == BUSY) begin
        if (erase_done) begin
          step       <= '0;
          addr_lat   <= '0;
          erase_chip <= 1'b0;
          erase_addr <= '0;
        end
      end else begin
        if (fall) addr_lat <= addr;
        if (rise) begin
          if (step == LAST) begin
            if (is_chip || is_sect) begin
              step        <= BUSY;
              erase_start <= 1'b1;
              erase_chip  <= is_chip;
              erase_addr  <= is_chip ? '0 : addr_lat;
            end else begin
              step <= '0;
            end
          end else begin
            step <= hit ? step + 3'd1 : 3'd0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we_n,
  input logic          erase_done,
  input logic          erase_start,
  input logic          erase_chip,
  input logic [AW-1:0] erase_addr,
  input logic          erase_active
);
  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_start_sets_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> erase_active);

  p_no_start_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_active |=> !erase_start);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && erase_done) |=> (!erase_active && !erase_chip && erase_addr == '0));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && !erase_done && !erase_start) |=> $stable(erase_addr));

  p_start_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_start) |-> ($past(we_n) && !$past(we_n, 2)));

  p_chip_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && erase_chip) |-> (erase_addr == '0));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .erase_done(erase_done),
  .erase_start(erase_start), .erase_chip(erase_chip),
  .erase_addr(erase_addr), .erase_active(erase_active));

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        erase_done = 1'b0;
  logic        erase_start, erase_chip, erase_active;
  logic [18:0] erase_addr;

  int checks = 0, errors = 0, starts = 0;
  logic last_chip;
  logic [18:0] last_addr;
  logic prev_start = 1'b0;

  // behavioural reference
  int m_step = 0;
  bit m_busy = 0, m_start = 0, m_chip = 0, m_prev_we = 1;
  logic [18:0] m_addr = '0, m_lat = '0;
  int unsigned exp_a[5] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA};
  int unsigned exp_d[5] = '{'hAA, 'h55, 'h80, 'hAA, 'h55};

  always #10 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .erase_done(erase_done), .erase_start(erase_start), .erase_chip(erase_chip),
    .erase_addr(erase_addr), .erase_active(erase_active));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_busy = 0; m_start = 0; m_chip = 0; m_prev_we = 1;
      m_addr = '0; m_lat = '0;
    end else begin
      m_start = 0;
      if (m_busy) begin
        if (erase_done) begin m_busy = 0; m_chip = 0; m_addr = '0; m_lat = '0; m_step = 0; end
      end else begin
        if (m_prev_we && !we_n) m_lat = addr;
        if (!m_prev_we && we_n) begin
          if (m_step == 5) begin
            if (wdata == 8'h10 || wdata == 8'h30) begin
              m_busy = 1; m_start = 1; m_chip = (wdata == 8'h10);
              m_addr = m_chip ? '0 : m_lat;
            end
            m_step = 0;
          end else if (m_lat[10:0] == exp_a[m_step][10:0] && wdata == exp_d[m_step][7:0])
            m_step++;
          else
            m_step = 0;
        end
      end
      m_prev_we = we_n;
    end
  end

  // compared on every clock: R2 R3 R7 R8 R9 R10
  always @(negedge clk) if (rst_n) begin
    chk("R9 R2 R3 start vs model", erase_start, m_start);
    chk("R7 R8 active vs model", erase_active, m_busy);
    chk("R2 R3 chip vs model", erase_chip, m_chip);
    chk("R3 R8 addr vs model", erase_addr, m_addr);
    if (erase_start) begin
      starts++; last_chip = erase_chip; last_addr = erase_addr;
      chk("R9 start width", prev_start, 0);
    end
    prev_start = erase_start;
  end

  task automatic wr(logic [18:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_move(logic [18:0] a1, logic [18:0] a2, logic [7:0] d);
    @(negedge clk); addr = a1; wdata = d; we_n = 1'b0;
    @(negedge clk); addr = a2;
    @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic prefix(logic [18:0] hi);
    wr(hi | 19'h555, 8'hAA); wr(hi | 19'h2AA, 8'h55); wr(hi | 19'h555, 8'h80);
    wr(hi | 19'h555, 8'hAA); wr(hi | 19'h2AA, 8'h55);
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset start", erase_start, 0);
    chk("R1 reset active", erase_active, 0);
    chk("R1 reset chip", erase_chip, 0);
    chk("R1 reset addr", erase_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 whole-array erase
    prefix('0); wr(19'h12345, 8'h10);
    chk("R2 one start", starts, 1);
    chk("R2 chip flag", last_chip, 1);
    chk("R7 active held", erase_active, 1);
    // R7 writes ignored while busy
    prefix('0); wr(19'h0, 8'h30);
    chk("R7 no start while busy", starts, 1);
    finish_erase();
    chk("R8 active cleared", erase_active, 0);
    chk("R8 chip cleared", erase_chip, 0);

    // R3 sector erase
    prefix('0); wr(19'h51234, 8'h30);
    chk("R3 second start", starts, 2);
    chk("R3 sector flag", last_chip, 0);
    chk("R3 sector addr", last_addr, 19'h51234);
    repeat (5) @(negedge clk);
    chk("R3 addr held", erase_addr, 19'h51234);
    finish_erase();
    chk("R8 addr cleared", erase_addr, 0);

    // R5 break in second write, then valid sequence
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h56);
    wr(19'h555, 8'h80); wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h0, 8'h10);
    chk("R5 broken sequence no start", starts, 2);
    // R5 bad sixth byte
    prefix('0); wr(19'h20000, 8'h20);
    chk("R5 bad command no start", starts, 2);
    prefix('0); wr(19'h20000, 8'h30);
    chk("R5 recovery start", starts, 3);
    chk("R5 recovery addr", last_addr, 19'h20000);
    finish_erase();

    // R6 upper address bits ignored in unlock writes
    prefix(19'h7F800); wr(19'h0, 8'h10);
    chk("R6 upper bits ignored", starts, 4);
    finish_erase();

    // R4 address taken on falling edge
    prefix('0); wr_move(19'h20001, 19'h60002, 8'h30);
    chk("R4 start", starts, 5);
    chk("R4 addr from falling edge", last_addr, 19'h20001);
    finish_erase();

    // R10 done while idle, mid-sequence
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55);
    finish_erase();
    chk("R10 active stays low", erase_active, 0);
    wr(19'h555, 8'h80); wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h30000, 8'h30);
    chk("R10 sequence survives done", starts, 6);
    chk("R10 addr", last_addr, 19'h30000);
    finish_erase();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule